// File: doc/BRIEF.md
# Deep Standby Power Sequencer

This block sequences a small microcontroller into and out of its deepest low-power state. It watches a one-cycle sleep strobe from the CPU. If three power-control bits agree at that moment, it turns off the CPU clock, the peripheral clocks and the oscillator enable. It also holds the serial, analog-converter and PWM peripherals in reset. CPU registers, RAM and the remaining peripherals keep their contents, because their clocks stop and nothing else happens to them.

Two kinds of event end standby. The first is an interrupt: the non-maskable input, or one of eight external lines that is enabled, not masked by the CPU and not routed to the transfer controller. The second is one of three reset-type pins. Either kind turns the oscillator back on at once and starts a settling wait whose length a 3-bit code selects. When the wait ends, the block spends one resume cycle with the clocks running. In that cycle it pulses an interrupt-exception-start output for an interrupt wake, or a reset-exit output for a pin wake.

The block also holds a register of per-module stop bits. Only the CPU may write it. A request to set the stop bit of either bus-master module (the DMA engine or the transfer controller) is refused while that module reports busy.

Top module: `standby_seq`

## Requirements
- R1: Standby is entered only when `sleep_stb` is 1 in the RUN state while `sel_stby`=1, `sel_lowspd`=0 and `sel_wdtpre`=0. Every other combination leaves the block in RUN on the next cycle.
- R2: In STANDBY, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R3: `per_rst` (bit 0 serial, bit 1 analog converter, bit 2 PWM) is all ones in STANDBY and SETTLE, and all zeros in RUN and RESUME.
- R4: In STANDBY, any of `nmi_in`, a qualified external line, `pin_rst`, `pin_mrst` or `pin_stby` moves the block to SETTLE on the next cycle.
- R5: In SETTLE, `osc_en` is 1 and both clock enables are 0. SETTLE lasts exactly 2^(n+8) cycles, where n is `settle_code` sampled on the wake cycle. After an interrupt wake, RESUME then raises `exc_start` for one cycle with both clocks enabled.
- R6: Settle codes 6 and 7 give the same wait as code 5 (8192 cycles).
- R7: External line i counts as a wake source only if `irq_in[i]`=1, `irq_en[i]`=1, `irq_cpu_mask[i]`=0 and `irq_xfer_sel[i]`=0. A line that fails any of these leaves the block in STANDBY.
- R8: A wake from a reset-type pin (this wins if an interrupt is also present) gives the same settling wait. RESUME then raises `rst_exit` instead of `exc_start`. The two outputs are never 1 together.
- R9: In the stop register, bit 7 belongs to the DMA engine and bit 6 to the transfer controller. A CPU write that would change a 0 in either of these bits to 1 leaves it 0 while that module's busy input is 1. Clearing these bits, and writing all other bits, always takes effect on the next cycle.
- R10: A write with `mstp_master_cpu`=0 leaves `mstp_q` unchanged.
- R11: A synchronous reset gives RUN, `osc_en`=1, both clock enables 1, `per_rst`=0, both pulses 0 and `mstp_q`=0.
- R12: `pwr_state` encodes RUN=0, STANDBY=1, SETTLE=2, RESUME=3. RESUME lasts one cycle and is followed by RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | One-cycle sleep strobe from the CPU |
| sel_stby | input | 1 | Standby-select control bit |
| sel_lowspd | input | 1 | Low-speed-select control bit |
| sel_wdtpre | input | 1 | Watchdog prescaler-select control bit |
| settle_code | input | 3 | Settling-wait code, sampled on the wake cycle |
| nmi_in | input | 1 | Non-maskable interrupt request |
| irq_in | input | 8 | External interrupt lines |
| irq_en | input | 8 | Per-line enable bits |
| irq_cpu_mask | input | 8 | Per-line CPU mask, 1 = masked |
| irq_xfer_sel | input | 8 | Per-line routing to the transfer controller |
| pin_rst | input | 1 | Reset pin wake |
| pin_mrst | input | 1 | Manual-reset pin wake |
| pin_stby | input | 1 | Standby pin wake |
| mstp_we | input | 1 | Stop-register write strobe |
| mstp_wdata | input | 16 | Stop-register write data |
| mstp_master_cpu | input | 1 | Current bus master is the CPU |
| dma_busy | input | 1 | DMA engine is active |
| dtc_busy | input | 1 | Transfer controller is active |
| mstp_q | output | 16 | Module stop bits |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| per_rst | output | 3 | Resets for serial, analog converter, PWM |
| exc_start | output | 1 | Interrupt-exception start pulse |
| rst_exit | output | 1 | Reset-type exit pulse |
| pwr_state | output | 2 | Current power state |

## Verification
The assertions assume that `rst` is held for at least one clock before the first checked cycle. They also assume that the busy inputs and the bus-master flag are stable within a cycle, so that a refused stop bit is judged against the busy value present at the same edge as the write. The stimulus changes every input only at the falling edge. It pulses `sleep_stb` for a single cycle, and it drops all wake inputs once SETTLE is reached, so each settling count is measured from one well-defined wake edge. Random interrupt patterns are drawn across enable, mask and routing, and each cycle's expected wake decision is recomputed from the R7 rule.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_STBY   = 2'd1,
        PS_SETTLE = 2'd2,
        PS_RESUME = 2'd3
    } pstate_e;

    typedef enum logic {
        WK_IRQ = 1'b0,
        WK_PIN = 1'b1
    } wake_kind_e;

    typedef struct packed {
        logic cpu_clk;
        logic per_clk;
        logic osc;
        logic hold_rst;
    } pwr_ctl_t;

    // Settling length in cycles for a code; codes above max_code clamp to it.
    function automatic int unsigned settle_cycles(input logic [2:0] code,
                                                  input int base_log,
                                                  input int max_code);
        int c;
        c = int'(code);
        if (c > max_code) c = max_code;
        return 32'd1 << (c + base_log);
    endfunction

    function automatic pwr_ctl_t ctl_for_state(input pstate_e s);
        pwr_ctl_t r;
        unique case (s)
            PS_RUN:    r = '{cpu_clk: 1'b1, per_clk: 1'b1, osc: 1'b1, hold_rst: 1'b0};
            PS_STBY:   r = '{cpu_clk: 1'b0, per_clk: 1'b0, osc: 1'b0, hold_rst: 1'b1};
            PS_SETTLE: r = '{cpu_clk: 1'b0, per_clk: 1'b0, osc: 1'b1, hold_rst: 1'b1};
            default:   r = '{cpu_clk: 1'b1, per_clk: 1'b1, osc: 1'b1, hold_rst: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pmu_wake_qual.sv
module pmu_wake_qual #(
    parameter int N_IRQ = 8
) (
    input  logic             nmi_in,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_cpu_mask,
    input  logic [N_IRQ-1:0] irq_xfer_sel,
    input  logic             pin_rst,
    input  logic             pin_mrst,
    input  logic             pin_stby,
    output logic             wake_irq,
    output logic             wake_pin
);
    logic [N_IRQ-1:0] line_ok;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign line_ok[i] = irq_in[i] & irq_en[i] & ~irq_cpu_mask[i] & ~irq_xfer_sel[i];
    end

    assign wake_irq = nmi_in | (|line_ok);
    assign wake_pin = pin_rst | pin_mrst | pin_stby;
endmodule

// File: rtl/pmu_settle_timer.sv
module pmu_settle_timer
    import pmu_pkg::*;
#(
    parameter int BASE_LOG = 8,
    parameter int MAX_CODE = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [2:0] code,
    input  logic       run,
    output logic       done
);
    localparam int CW = BASE_LOG + MAX_CODE;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(settle_cycles(code, BASE_LOG, MAX_CODE) - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/pmu_mstp_reg.sv
module pmu_mstp_reg #(
    parameter int NMOD    = 16,
    parameter int DMA_BIT = 7,
    parameter int DTC_BIT = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [NMOD-1:0] wdata,
    input  logic            master_cpu,
    input  logic            dma_busy,
    input  logic            dtc_busy,
    output logic [NMOD-1:0] q
);
    logic accept;
    assign accept = we & master_cpu;

    for (genvar i = 0; i < NMOD; i++) begin : g_bit
        logic busy;
        if (i == DMA_BIT) begin : g_dma
            assign busy = dma_busy;
        end else if (i == DTC_BIT) begin : g_dtc
            assign busy = dtc_busy;
        end else begin : g_free
            assign busy = 1'b0;
        end

        logic refuse;
        assign refuse = busy & wdata[i] & ~q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (accept && !refuse) begin
                q[i] <= wdata[i];
            end
        end
    end
endmodule

// File: rtl/standby_seq.sv
module standby_seq
    import pmu_pkg::*;
#(
    parameter int N_IRQ    = 8,
    parameter int NMOD     = 16,
    parameter int DMA_BIT  = 7,
    parameter int DTC_BIT  = 6,
    parameter int N_PRST   = 3,
    parameter int BASE_LOG = 8,
    parameter int MAX_CODE = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_stb,
    input  logic              sel_stby,
    input  logic              sel_lowspd,
    input  logic              sel_wdtpre,
    input  logic [2:0]        settle_code,
    input  logic              nmi_in,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic [N_IRQ-1:0]  irq_cpu_mask,
    input  logic [N_IRQ-1:0]  irq_xfer_sel,
    input  logic              pin_rst,
    input  logic              pin_mrst,
    input  logic              pin_stby,
    input  logic              mstp_we,
    input  logic [NMOD-1:0]   mstp_wdata,
    input  logic              mstp_master_cpu,
    input  logic              dma_busy,
    input  logic              dtc_busy,
    output logic [NMOD-1:0]   mstp_q,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic [N_PRST-1:0] per_rst,
    output logic              exc_start,
    output logic              rst_exit,
    output logic [1:0]        pwr_state
);
    pstate_e    state_q, state_d;
    wake_kind_e kind_q;
    logic       wake_irq, wake_pin, settle_done, go_sleep, wake_now;
    pwr_ctl_t   ctl;

    pmu_wake_qual #(.N_IRQ(N_IRQ)) wake_i (
        .nmi_in       (nmi_in),
        .irq_in       (irq_in),
        .irq_en       (irq_en),
        .irq_cpu_mask (irq_cpu_mask),
        .irq_xfer_sel (irq_xfer_sel),
        .pin_rst      (pin_rst),
        .pin_mrst     (pin_mrst),
        .pin_stby     (pin_stby),
        .wake_irq     (wake_irq),
        .wake_pin     (wake_pin)
    );

    assign go_sleep = sleep_stb & sel_stby & ~sel_lowspd & ~sel_wdtpre;
    assign wake_now = (state_q == PS_STBY) & (wake_irq | wake_pin);

    pmu_settle_timer #(.BASE_LOG(BASE_LOG), .MAX_CODE(MAX_CODE)) tmr_i (
        .clk  (clk),
        .rst  (rst),
        .load (wake_now),
        .code (settle_code),
        .run  (state_q == PS_SETTLE),
        .done (settle_done)
    );

    pmu_mstp_reg #(.NMOD(NMOD), .DMA_BIT(DMA_BIT), .DTC_BIT(DTC_BIT)) mstp_i (
        .clk        (clk),
        .rst        (rst),
        .we         (mstp_we),
        .wdata      (mstp_wdata),
        .master_cpu (mstp_master_cpu),
        .dma_busy   (dma_busy),
        .dtc_busy   (dtc_busy),
        .q          (mstp_q)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:    if (go_sleep) state_d = PS_STBY;
            PS_STBY:   if (wake_now) state_d = PS_SETTLE;
            PS_SETTLE: if (settle_done) state_d = PS_RESUME;
            default:   state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_RUN;
            kind_q  <= WK_IRQ;
        end else begin
            state_q <= state_d;
            if (wake_now) kind_q <= wake_pin ? WK_PIN : WK_IRQ;
        end
    end

    assign ctl        = ctl_for_state(state_q);
    assign cpu_clk_en = ctl.cpu_clk;
    assign per_clk_en = ctl.per_clk;
    assign osc_en     = ctl.osc;
    assign per_rst    = {N_PRST{ctl.hold_rst}};
    assign exc_start  = (state_q == PS_RESUME) && (kind_q == WK_IRQ);
    assign rst_exit   = (state_q == PS_RESUME) && (kind_q == WK_PIN);
    assign pwr_state  = state_q;
endmodule

// File: rtl/standby_seq_sva.sv
module standby_seq_sva
    import pmu_pkg::*;
#(
    parameter int N_IRQ   = 8,
    parameter int NMOD    = 16,
    parameter int DMA_BIT = 7,
    parameter int DTC_BIT = 6,
    parameter int N_PRST  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_stb,
    input logic              sel_stby,
    input logic              sel_lowspd,
    input logic              sel_wdtpre,
    input logic              nmi_in,
    input logic [N_IRQ-1:0]  irq_in,
    input logic [N_IRQ-1:0]  irq_en,
    input logic [N_IRQ-1:0]  irq_cpu_mask,
    input logic [N_IRQ-1:0]  irq_xfer_sel,
    input logic              pin_rst,
    input logic              pin_mrst,
    input logic              pin_stby,
    input logic              mstp_we,
    input logic              mstp_master_cpu,
    input logic              dma_busy,
    input logic              dtc_busy,
    input logic [NMOD-1:0]   mstp_q,
    input logic              cpu_clk_en,
    input logic              per_clk_en,
    input logic              osc_en,
    input logic [N_PRST-1:0] per_rst,
    input logic              exc_start,
    input logic              rst_exit,
    input logic [1:0]        pwr_state
);
    // R1
    no_bad_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_RUN && !(sleep_stb && sel_stby && !sel_lowspd && !sel_wdtpre))
        |=> pwr_state == PS_RUN);

    // R2
    stby_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_STBY) |-> (!cpu_clk_en && !per_clk_en && !osc_en));

    // R3
    stby_rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_STBY || pwr_state == PS_SETTLE) |-> (&per_rst));

    // R5
    osc_before_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> $past(osc_en));

    // R7
    no_false_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_STBY && !nmi_in && !pin_rst && !pin_mrst && !pin_stby &&
         ((irq_in & irq_en & ~irq_cpu_mask & ~irq_xfer_sel) == '0))
        |=> pwr_state == PS_STBY);

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(exc_start && rst_exit));

    // R9
    dma_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_busy && !mstp_q[DMA_BIT]) |=> !mstp_q[DMA_BIT]);

    // R9
    dtc_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (dtc_busy && !mstp_q[DTC_BIT]) |=> !mstp_q[DTC_BIT]);

    // R10
    foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!mstp_we || !mstp_master_cpu) |=> $stable(mstp_q));

    // R12
    resume_once_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_RESUME) |=> pwr_state == PS_RUN);
endmodule

bind standby_seq standby_seq_sva #(
    .N_IRQ(N_IRQ), .NMOD(NMOD), .DMA_BIT(DMA_BIT), .DTC_BIT(DTC_BIT), .N_PRST(N_PRST)
) chk_i (.*);

// File: tb/standby_seq_tb_top.sv
module standby_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_stb = 0, sel_stby = 0, sel_lowspd = 0, sel_wdtpre = 0;
    logic [2:0]  settle_code = 0;
    logic        nmi_in = 0;
    logic [7:0]  irq_in = 0, irq_en = 0, irq_cpu_mask = 0, irq_xfer_sel = 0;
    logic        pin_rst = 0, pin_mrst = 0, pin_stby = 0;
    logic        mstp_we = 0, mstp_master_cpu = 1, dma_busy = 0, dtc_busy = 0;
    logic [15:0] mstp_wdata = 0;
    logic [15:0] mstp_q;
    logic        cpu_clk_en, per_clk_en, osc_en, exc_start, rst_exit;
    logic [2:0]  per_rst;
    logic [1:0]  pwr_state;

    int vec = 0, err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    standby_seq dut_i (.*);

    function automatic bit exp_enter(bit s, bit l, bit w);
        return s && !l && !w;
    endfunction

    function automatic int exp_len(int code);
        int c = (code > 5) ? 5 : code;
        return 1 << (c + 8);
    endfunction

    function automatic bit exp_irq_wake(logic [7:0] i, logic [7:0] e, logic [7:0] m, logic [7:0] x);
        return |(i & e & ~m & ~x);
    endfunction

    function automatic logic [15:0] exp_mstp(logic [15:0] old, logic [15:0] wd, bit cpu, bit db, bit tb);
        logic [15:0] n;
        if (!cpu) return old;
        n = wd;
        if (db && wd[7] && !old[7]) n[7] = 1'b0;
        if (tb && wd[6] && !old[6]) n[6] = 1'b0;
        return n;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act !== exp) begin
            err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_wake;
        nmi_in = 0; irq_in = 0; pin_rst = 0; pin_mrst = 0; pin_stby = 0;
    endtask

    // Enter standby from RUN; returns whether it entered.
    task automatic try_sleep(input bit s, input bit l, input bit w, output bit entered);
        sel_stby = s; sel_lowspd = l; sel_wdtpre = w; sleep_stb = 1;
        tick;
        sleep_stb = 0;
        entered = exp_enter(s, l, w);
        chk("R1 entry", pwr_state, entered ? 1 : 0);
        if (entered) begin
            chk("R2 clocks/osc off", {cpu_clk_en, per_clk_en, osc_en}, 0);
            chk("R3 per_rst in standby", per_rst, 7);
        end
    endtask

    // Wake inputs are already driven; settle_code set.
    task automatic settle_and_resume(input int code, input bit pin, input string tag);
        int n = 0;
        tick;
        clear_wake;
        chk({tag, " R4 to settle"}, pwr_state, 2);
        chk("R5 osc on, clocks off in settle", {cpu_clk_en, per_clk_en, osc_en}, 1);
        chk("R3 per_rst in settle", per_rst, 7);
        while (!exc_start && !rst_exit && n < 9000) begin
            tick;
            n++;
        end
        chk({tag, " R5/R6 settle length"}, n, exp_len(code));
        chk({tag, " R8 exit pulse kind"}, {exc_start, rst_exit}, pin ? 1 : 2);
        chk("R12 resume state", pwr_state, 3);
        chk("R5 clocks on at resume", {cpu_clk_en, per_clk_en, osc_en}, 7);
        chk("R3 per_rst released at resume", per_rst, 0);
        tick;
        chk("R12 back to run", pwr_state, 0);
        chk("R5 pulse lasts one cycle", {exc_start, rst_exit}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    end

    initial begin
        bit ent;
        logic [15:0] model;
        void'($urandom(32'h5eed_0042));
        repeat (4) tick;
        rst = 0;
        tick;
        // R11 reset state
        chk("R11 reset state", pwr_state, 0);
        chk("R11 reset outputs", {cpu_clk_en, per_clk_en, osc_en, per_rst, exc_start, rst_exit}, 8'b1110_0000);
        chk("R11 reset mstp", mstp_q, 0);

        // R1 non-entry combinations
        try_sleep(1, 1, 0, ent);
        try_sleep(1, 0, 1, ent);
        try_sleep(0, 0, 0, ent);

        // R7 disqualified lines, then qualified wake with code 0
        try_sleep(1, 0, 0, ent);
        irq_in = 8'h04; irq_en = 8'h00; tick;
        chk("R7 disabled line ignored", pwr_state, 1);
        irq_en = 8'h04; irq_cpu_mask = 8'h04; tick;
        chk("R7 masked line ignored", pwr_state, 1);
        irq_cpu_mask = 0; irq_xfer_sel = 8'h04; tick;
        chk("R7 transfer-routed line ignored", pwr_state, 1);
        irq_xfer_sel = 0;
        settle_code = 0;
        settle_and_resume(0, 0, "irq code0");

        // R6 clamped code
        try_sleep(1, 0, 0, ent);
        settle_code = 7; nmi_in = 1;
        settle_and_resume(7, 0, "nmi code7");

        // R8 pin wake wins over simultaneous interrupt
        try_sleep(1, 0, 0, ent);
        settle_code = 1; pin_mrst = 1; nmi_in = 1;
        settle_and_resume(1, 1, "pin code1");

        // Random standby sequences
        for (int it = 0; it < 10; it++) begin
            bit s = $urandom_range(0, 1) != 0, l = $urandom_range(0, 3) == 0, w = $urandom_range(0, 3) == 0;
            try_sleep(s, l, w, ent);
            if (ent) begin
                bit woke = 0;
                int code = $urandom_range(0, 3);
                settle_code = 3'(code);
                for (int k = 0; k < 4 && !woke; k++) begin
                    irq_in = 8'($urandom); irq_en = 8'($urandom);
                    irq_cpu_mask = 8'($urandom); irq_xfer_sel = 8'($urandom);
                    woke = exp_irq_wake(irq_in, irq_en, irq_cpu_mask, irq_xfer_sel);
                    if (!woke) begin
                        tick;
                        chk("R7 random unqualified pattern", pwr_state, 1);
                    end
                end
                if (woke) begin
                    settle_and_resume(code, 0, "random irq");
                end else begin
                    clear_wake; pin_stby = 1;
                    settle_and_resume(code, 1, "random pin");
                end
                irq_en = 0; irq_cpu_mask = 0; irq_xfer_sel = 0;
            end
        end

        // R9 directed: busy refuses set, clear while busy accepted
        model = mstp_q;
        dma_busy = 1; dtc_busy = 1; mstp_we = 1; mstp_wdata = 16'hFFFF; tick;
        chk("R9 busy refuses bus-master bits", mstp_q, 16'hFF3F);
        dma_busy = 0; dtc_busy = 0; tick;
        chk("R9 idle accepts bus-master bits", mstp_q, 16'hFFFF);
        dma_busy = 1; dtc_busy = 1; mstp_wdata = 16'h0000; tick;
        chk("R9 clear accepted while busy", mstp_q, 0);
        mstp_master_cpu = 0; mstp_wdata = 16'h1234; tick;
        chk("R10 non-CPU write dropped", mstp_q, 0);
        model = mstp_q;

        // R9/R10 random writes
        for (int it = 0; it < 80; it++) begin
            mstp_we = $urandom_range(0, 3) != 0;
            mstp_wdata = 16'($urandom);
            mstp_master_cpu = $urandom_range(0, 3) != 0;
            dma_busy = $urandom_range(0, 1) != 0;
            dtc_busy = $urandom_range(0, 1) != 0;
            if (mstp_we)
                model = exp_mstp(model, mstp_wdata, mstp_master_cpu, dma_busy, dtc_busy);
            tick;
            chk("R9/R10 random stop-register write", mstp_q, model);
        end
        mstp_we = 0;

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end
endmodule